// File: doc/BRIEF.md
# Byte ALU with Flag Rules

This block is the purely combinational arithmetic and logic stage of a small 8-bit controller. Each cycle the surrounding datapath presents two operand bytes, an operation code, and the current carry and zero flags. The block returns a result byte with its own write-enable, and a new value plus a write-enable for each of the two flags. Operand fetch, addressing and the register file all sit outside it.

The flag behaviour differs from one operation to the next. Increment raises carry and zero together when it wraps. Complement touches only zero. Compare and test compute a value but leave their first operand unwritten. A group of logic operations aimed at the flag register changes carry only through bit 2 of the immediate operand. When a flag's write-enable is low, the block passes that flag's incoming value through, so the caller can latch all three outputs without extra muxing.

Top module: `bytealu`

## Requirements
- R1: Operation codes on `op` are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 increment, 6 decrement, 7 AND, 8 OR, 9 XOR, 10 test, 11 complement, 12 shift left, 13 arithmetic shift right, 14 rotate left through carry, 15 rotate right through carry, 16 flag-AND, 17 flag-OR, 18 flag-XOR. Codes 19 to 31 drive `result` to 0, hold `result_we`, `carry_we` and `zero_we` low, and pass both flags through.
- R2: Add gives (a+b) mod 256 and add-with-carry gives (a+b+carry_in) mod 256. Carry is set when the true sum exceeds 255, and zero is set when the byte result is 0.
- R3: Subtract gives a−b and subtract-with-borrow gives a−b−carry_in, both mod 256. Carry is set when the true difference is negative, and zero when the byte is 0. Compare updates the flags exactly like subtract, with `result_we` low.
- R4: Increment gives a+1, and it sets carry and zero together exactly when the result wraps to 0x00.
- R5: Decrement gives a−1, sets carry exactly when a was 0, and sets zero exactly when the result is 0.
- R6: AND, OR, XOR and complement (~a) write the result and set zero from it. They hold `carry_we` low, so `carry_out` equals `carry_in`.
- R7: Test sets zero from a AND b, holds `result_we` low, and leaves carry unwritten.
- R8: Flag-AND, flag-OR and flag-XOR write a op b as the result and set `carry_out` to carry_in op b[2] with `carry_we` high. They hold `zero_we` low, so `zero_out` equals `zero_in`.
- R9: Shift left gives {a[6:0],0} with carry from a[7]. Arithmetic shift right gives {a[7],a[7:1]} with carry from a[0]. Both set zero from the result.
- R10: Rotate left gives {a[6:0],carry_in} with carry from a[7]. Rotate right gives {carry_in,a[7:1]} with carry from a[0]. Both set zero from the result.
- R11: Whenever a flag's write-enable is low, that flag's output equals its incoming value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code |
| a | input | 8 | First operand (accumulator, memory byte or flag byte) |
| b | input | 8 | Second operand or immediate |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag |
| result | output | 8 | Result byte |
| result_we | output | 1 | Result is to be written back |
| carry_out | output | 1 | New carry flag |
| carry_we | output | 1 | Carry flag is to be written |
| zero_out | output | 1 | New zero flag |
| zero_we | output | 1 | Zero flag is to be written |

## Verification
The hardest cases to reach are the ones where a flag must stay put, because a stuck pass-through looks correct whenever the incoming flag already matches the expected value. The directed tasks therefore drive every carry-preserving and zero-preserving operation with both polarities of the incoming flag. They also pick operands where the flag-register operations give a carry that differs from both the incoming carry and b[2] alone. The wrap boundaries 0x00 and 0xFF are hit on purpose for increment, decrement and borrow. A seeded sweep then covers every code with mixed operand patterns.

// File: rtl/bytealu_pkg.sv
package bytealu_pkg;

    localparam int OP_W     = 5;
    localparam int CARRY_TAP = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_CMP  = 5'd4,
        OP_INC  = 5'd5,
        OP_DEC  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_TST  = 5'd10,
        OP_CPL  = 5'd11,
        OP_ASL  = 5'd12,
        OP_ASR  = 5'd13,
        OP_RLC  = 5'd14,
        OP_RRC  = 5'd15,
        OP_ANDF = 5'd16,
        OP_ORF  = 5'd17,
        OP_XORF = 5'd18
    } op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_NONE
    } cls_e;

    // write controls produced by each functional unit
    typedef struct packed {
        logic res_we;
        logic c;
        logic c_we;
        logic z_we;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{res_we: 1'b0, c: 1'b0, c_we: 1'b0, z_we: 1'b0};

    function automatic cls_e op_class(input logic [OP_W-1:0] code);
        cls_e k;
        case (code)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB,
            OP_CMP, OP_INC, OP_DEC:           k = CLS_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_TST,
            OP_CPL, OP_ANDF, OP_ORF, OP_XORF: k = CLS_LOGIC;
            OP_ASL, OP_ASR, OP_RLC, OP_RRC:   k = CLS_SHIFT;
            default:                          k = CLS_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/bytealu_arith.sv
module bytealu_arith
    import bytealu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output ctl_t         ctl
);
    localparam int XW = W + 1;

    logic [XW-1:0] ax, bx, cx, ext;

    assign ax = {1'b0, a};
    assign bx = {1'b0, b};
    assign cx = {{W{1'b0}}, cin};

    always_comb begin
        ctl = '{res_we: 1'b1, c: 1'b0, c_we: 1'b1, z_we: 1'b1};
        case (op)
            OP_ADD:  ext = ax + bx;
            OP_ADC:  ext = ax + bx + cx;
            OP_SUB:  ext = ax - bx;
            OP_SBB:  ext = ax - bx - cx;
            OP_CMP: begin
                ext        = ax - bx;
                ctl.res_we = 1'b0;
            end
            OP_INC:  ext = ax + XW'(1);
            OP_DEC:  ext = ax - XW'(1);
            default: begin
                ext = '0;
                ctl = CTL_IDLE;
            end
        endcase
        // bit W is the carry on addition and the borrow on subtraction
        ctl.c = ctl.c_we & ext[W];
        res   = ext[W-1:0];
    end

endmodule

// File: rtl/bytealu_logic.sv
module bytealu_logic
    import bytealu_pkg::*;
#(
    parameter int W   = 8,
    parameter int TAP = CARRY_TAP
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output ctl_t         ctl
);
    logic bt;
    assign bt = b[TAP];

    always_comb begin
        res = '0;
        ctl = '{res_we: 1'b1, c: 1'b0, c_we: 1'b0, z_we: 1'b1};
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CPL:  res = ~a;
            OP_TST: begin
                res        = a & b;
                ctl.res_we = 1'b0;
            end
            OP_ANDF: begin
                res  = a & b;
                ctl  = '{res_we: 1'b1, c: cin & bt, c_we: 1'b1, z_we: 1'b0};
            end
            OP_ORF: begin
                res  = a | b;
                ctl  = '{res_we: 1'b1, c: cin | bt, c_we: 1'b1, z_we: 1'b0};
            end
            OP_XORF: begin
                res  = a ^ b;
                ctl  = '{res_we: 1'b1, c: cin ^ bt, c_we: 1'b1, z_we: 1'b0};
            end
            default: ctl = CTL_IDLE;
        endcase
    end

endmodule

// File: rtl/bytealu_shift.sv
module bytealu_shift
    import bytealu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output ctl_t         ctl
);
    logic left, fill_lo, fill_hi;

    always_comb begin
        ctl     = '{res_we: 1'b1, c: 1'b0, c_we: 1'b1, z_we: 1'b1};
        left    = 1'b0;
        fill_lo = 1'b0;
        fill_hi = 1'b0;
        case (op)
            OP_ASL:  left = 1'b1;
            OP_ASR:  fill_hi = a[W-1];
            OP_RLC: begin
                left    = 1'b1;
                fill_lo = cin;
            end
            OP_RRC:  fill_hi = cin;
            default: ctl = CTL_IDLE;
        endcase
        if (left) begin
            res   = {a[W-2:0], fill_lo};
            ctl.c = ctl.c_we & a[W-1];
        end else begin
            res   = {fill_hi, a[W-1:1]};
            ctl.c = ctl.c_we & a[0];
        end
    end

endmodule

// File: rtl/bytealu.sv
module bytealu
    import bytealu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            carry_in,
    input  logic            zero_in,
    output logic [W-1:0]    result,
    output logic            result_we,
    output logic            carry_out,
    output logic            carry_we,
    output logic            zero_out,
    output logic            zero_we
);
    op_e          code;
    cls_e         cls;
    logic [W-1:0] ar_res, lg_res, sh_res, sel_res;
    ctl_t         ar_ctl, lg_ctl, sh_ctl, sel_ctl;

    assign code = op_e'(op);
    assign cls  = op_class(op);

    bytealu_arith #(.W(W)) u_arith (
        .op(code), .a(a), .b(b), .cin(carry_in), .res(ar_res), .ctl(ar_ctl)
    );

    bytealu_logic #(.W(W), .TAP(CARRY_TAP)) u_logic (
        .op(code), .a(a), .b(b), .cin(carry_in), .res(lg_res), .ctl(lg_ctl)
    );

    bytealu_shift #(.W(W)) u_shift (
        .op(code), .a(a), .cin(carry_in), .res(sh_res), .ctl(sh_ctl)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: begin sel_res = ar_res; sel_ctl = ar_ctl; end
            CLS_LOGIC: begin sel_res = lg_res; sel_ctl = lg_ctl; end
            CLS_SHIFT: begin sel_res = sh_res; sel_ctl = sh_ctl; end
            default:   begin sel_res = '0;     sel_ctl = CTL_IDLE; end
        endcase
    end

    // one shared zero detector serves every unit
    assign result    = sel_res;
    assign result_we = sel_ctl.res_we;
    assign carry_we  = sel_ctl.c_we;
    assign zero_we   = sel_ctl.z_we;
    assign carry_out = sel_ctl.c_we ? sel_ctl.c : carry_in;
    assign zero_out  = sel_ctl.z_we ? (sel_res == '0) : zero_in;

endmodule

// File: rtl/bytealu_chk.sv
module bytealu_chk
    import bytealu_pkg::*;
#(
    parameter int W = 8
) (
    input logic [OP_W-1:0] op,
    input logic [W-1:0]    a,
    input logic [W-1:0]    b,
    input logic            carry_in,
    input logic            zero_in,
    input logic [W-1:0]    result,
    input logic            result_we,
    input logic            carry_out,
    input logic            carry_we,
    input logic            zero_out,
    input logic            zero_we
);
    always_comb begin
        // R11: unwritten flags pass through
        if (!carry_we)
            a_r11_carry_hold: assert (carry_out == carry_in);
        if (!zero_we)
            a_r11_zero_hold: assert (zero_out == zero_in);
        // R3 / R7: compare and test never write back
        if (op == OP_CMP || op == OP_TST)
            a_r3_r7_no_writeback: assert (!result_we);
        // R4: increment raises carry and zero together
        if (op == OP_INC)
            a_r4_inc_flags_pair: assert (carry_out == zero_out && zero_out == (a == {W{1'b1}}));
        // R6: complement keeps carry
        if (op == OP_CPL)
            a_r6_cpl_keeps_carry: assert (!carry_we && result == ~a);
        // R8: flag-register ops write carry, never zero
        if (op == OP_ANDF || op == OP_ORF || op == OP_XORF)
            a_r8_flagop_enables: assert (carry_we && !zero_we && result_we);
        // R1: unassigned codes write nothing
        if (op > OP_XORF)
            a_r1_idle_code: assert (!result_we && !carry_we && !zero_we && result == '0);
        // R5: decrement carry only from a zero operand
        if (op == OP_DEC)
            a_r5_dec_carry: assert (carry_out == (a == '0));
    end
endmodule

bind bytealu bytealu_chk #(.W(W)) u_chk (
    .op(op), .a(a), .b(b), .carry_in(carry_in), .zero_in(zero_in),
    .result(result), .result_we(result_we), .carry_out(carry_out),
    .carry_we(carry_we), .zero_out(zero_out), .zero_we(zero_we)
);

// File: tb/bytealu_test.sv
module bytealu_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op  = 5'd31;
    logic [7:0] a   = '0;
    logic [7:0] b   = '0;
    logic       ci  = 1'b0;
    logic       zi  = 1'b0;
    logic [7:0] result;
    logic       result_we, carry_out, carry_we, zero_out, zero_we;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    bytealu uut (
        .op(op), .a(a), .b(b), .carry_in(ci), .zero_in(zi),
        .result(result), .result_we(result_we), .carry_out(carry_out),
        .carry_we(carry_we), .zero_out(zero_out), .zero_we(zero_we)
    );

    // reference model from the requirements
    task automatic model(input int o, input int x, input int y, input int c, input int z,
                         output int r, output int rwe, output int co, output int cwe,
                         output int zo, output int zwe);
        int s;
        s = 0; r = 0; rwe = 1; cwe = 1; zwe = 1; co = c;
        case (o)
            0:  begin s = x + y;         co = (s > 255); end
            1:  begin s = x + y + c;     co = (s > 255); end
            2:  begin s = x - y;         co = (s < 0);   end
            3:  begin s = x - y - c;     co = (s < 0);   end
            4:  begin s = x - y;         co = (s < 0); rwe = 0; end
            5:  begin s = x + 1;         co = (s > 255); end
            6:  begin s = x - 1;         co = (x == 0);  end
            7:  begin s = x & y; cwe = 0; end
            8:  begin s = x | y; cwe = 0; end
            9:  begin s = x ^ y; cwe = 0; end
            10: begin s = x & y; cwe = 0; rwe = 0; end
            11: begin s = 255 - x; cwe = 0; end
            12: begin s = (x * 2) & 255;            co = (x >> 7) & 1; end
            13: begin s = (x & 128) | (x >> 1);     co = x & 1; end
            14: begin s = ((x * 2) & 255) | c;      co = (x >> 7) & 1; end
            15: begin s = (c * 128) | (x >> 1);     co = x & 1; end
            16: begin s = x & y; co = c & ((y >> 2) & 1); zwe = 0; end
            17: begin s = x | y; co = c | ((y >> 2) & 1); zwe = 0; end
            18: begin s = x ^ y; co = c ^ ((y >> 2) & 1); zwe = 0; end
            default: begin s = 0; rwe = 0; cwe = 0; zwe = 0; end
        endcase
        r  = s & 255;
        if (cwe == 0) co = c;
        zo = zwe ? (r == 0) : z;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input string req, input int o, input int x, input int y,
                         input int c, input int z);
        int r, rwe, co, cwe, zo, zwe;
        @(negedge clk);
        op = 5'(o); a = 8'(x); b = 8'(y); ci = c[0]; zi = z[0];
        #1;
        model(o, x, y, c, z, r, rwe, co, cwe, zo, zwe);
        chk(req, "result_we", int'(result_we), rwe);
        if (rwe != 0 || o > 18) chk(req, "result", int'(result), r);
        chk(req, "carry_we", int'(carry_we), cwe);
        chk(req, "carry_out", int'(carry_out), co);
        chk(req, "zero_we", int'(zero_we), zwe);
        chk(req, "zero_out", int'(zero_out), zo);
    endtask

    task automatic t_idle();   // R1 idle codes, state after reset
        apply("R1", 31, 8'hA5, 8'h5A, 1, 1);
        apply("R1", 19, 8'h00, 8'hFF, 0, 0);
        apply("R1", 25, 8'hFF, 8'hFF, 1, 0);
    endtask

    task automatic t_add();    // R2
        apply("R2", 0, 8'h7F, 8'h01, 1, 0);
        apply("R2", 0, 8'hFF, 8'h01, 0, 0);
        apply("R2", 0, 8'h80, 8'h80, 1, 0);
        apply("R2", 1, 8'hFE, 8'h01, 1, 0);
        apply("R2", 1, 8'hFF, 8'hFF, 1, 1);
        apply("R2", 1, 8'h10, 8'h20, 0, 1);
    endtask

    task automatic t_sub();    // R3
        apply("R3", 2, 8'h05, 8'h05, 1, 0);
        apply("R3", 2, 8'h04, 8'h05, 0, 1);
        apply("R3", 3, 8'h05, 8'h05, 1, 0);
        apply("R3", 3, 8'h06, 8'h05, 1, 0);
        apply("R3", 3, 8'h00, 8'hFF, 1, 0);
        apply("R3", 4, 8'h33, 8'h33, 0, 0);
        apply("R3", 4, 8'h10, 8'h80, 0, 1);
    endtask

    task automatic t_incdec(); // R4, R5
        apply("R4", 5, 8'hFF, 8'h00, 0, 0);
        apply("R4", 5, 8'h7F, 8'h00, 1, 1);
        apply("R5", 6, 8'h00, 8'h00, 0, 1);
        apply("R5", 6, 8'h01, 8'h00, 1, 0);
        apply("R5", 6, 8'h80, 8'h00, 1, 1);
    endtask

    task automatic t_logic();  // R6, R7, R11
        for (int c = 0; c < 2; c++) begin
            apply("R6", 7,  8'hF0, 8'h0F, c, 1);
            apply("R6", 8,  8'h00, 8'h00, c, 0);
            apply("R6", 9,  8'hAA, 8'h55, c, 1);
            apply("R6", 11, 8'hFF, 8'h00, c, 0);
            apply("R6", 11, 8'h3C, 8'h00, c, 1);
            apply("R7", 10, 8'hC3, 8'h3C, c, 0);
            apply("R7", 10, 8'hC3, 8'h01, c, 1);
        end
    endtask

    task automatic t_flagops(); // R8, R11
        for (int c = 0; c < 2; c++) begin
            for (int z = 0; z < 2; z++) begin
                apply("R8", 16, 8'h07, 8'h04, c, z);
                apply("R8", 16, 8'hFF, 8'hFB, c, z);
                apply("R8", 17, 8'h00, 8'h04, c, z);
                apply("R8", 17, 8'h00, 8'h00, c, z);
                apply("R8", 18, 8'h04, 8'h04, c, z);
                apply("R8", 18, 8'h12, 8'h0B, c, z);
            end
        end
    endtask

    task automatic t_shift();  // R9
        apply("R9", 12, 8'h80, 8'h00, 0, 0);
        apply("R9", 12, 8'h41, 8'h00, 1, 1);
        apply("R9", 13, 8'h81, 8'h00, 0, 0);
        apply("R9", 13, 8'h01, 8'h00, 0, 0);
        apply("R9", 13, 8'h7E, 8'h00, 1, 1);
    endtask

    task automatic t_rotate(); // R10
        apply("R10", 14, 8'h80, 8'h00, 0, 0);
        apply("R10", 14, 8'h80, 8'h00, 1, 0);
        apply("R10", 14, 8'h01, 8'h00, 1, 1);
        apply("R10", 15, 8'h01, 8'h00, 0, 0);
        apply("R10", 15, 8'h01, 8'h00, 1, 1);
        apply("R10", 15, 8'hFE, 8'h00, 0, 0);
    endtask

    task automatic t_sweep();  // R1..R11 under mixed operands
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            apply("R11", i % 21, int'(lf[7:0]), int'(lf[15:8]), int'(lf[3]), int'(lf[9]));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_add();
        t_sub();
        t_incdec();
        t_logic();
        t_flagops();
        t_shift();
        t_rotate();
        t_sweep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule